// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two IEEE-754 operands, A and B, and returns the ordering as a 4-bit condition nibble. Each ordering outcome (A equal to B, A less than B, A greater than B, unordered) maps to one fixed nibble. The block also returns an invalid-operation flag. One select input chooses single precision (32-bit) or double precision (64-bit) operands. A second select chooses a quiet compare or a signalling compare. The two compares differ only in when they raise invalid.

The logic is combinational. By default a single register stage follows it, so a result appears one clock after its operands. The block handles signed zeros, infinities, quiet NaNs and signalling NaNs. Denormal inputs are compared exactly as encoded, with no flushing. A processor pipeline uses the nibble as the flag result of a floating-point compare instruction.

Top module: `fpcmp_top`

## Requirements
- R1: For non-NaN operands with A equal to B, nzcv is 4'b0110 (bit 3 N, bit 2 Z, bit 1 C, bit 0 V), so Z and C are set, and invalid is 0.
- R2: For non-NaN operands with A less than B, nzcv is 4'b1000 (only N set) and invalid is 0.
- R3: For non-NaN operands with A greater than B, nzcv is 4'b0010 (only C set) and invalid is 0.
- R4: If either operand is a NaN (exponent all ones and fraction non-zero), nzcv is 4'b0011 (C and V set, N and Z clear).
- R5: Positive zero and negative zero compare equal in either precision, in either order.
- R6: Infinities are ordered: -inf is below every finite value, +inf is above every finite value, and two infinities of the same sign are equal.
- R7: With sig_mode=0 (quiet compare), invalid is 1 only when at least one operand is a signalling NaN, that is a NaN whose fraction MSB is 0. A quiet NaN, whose fraction MSB is 1, gives unordered with invalid=0.
- R8: With sig_mode=1 (signalling compare), invalid is 1 whenever either operand is a NaN of either kind.
- R9: With dbl_sel=0, only bits [31:0] of each operand are used (sign bit 31, exponent [30:23], fraction [22:0]), and bits [63:32] have no effect. With dbl_sel=1, all 64 bits are used (sign bit 63, exponent [62:52], fraction [51:0]).
- R10: With OUT_REG=1, nzcv and invalid show the compare of the operands present at the previous rising clock edge. While rst is high they are cleared to 0 at each edge.
- R11: Two negative non-NaN operands order by reversed magnitude, so -2.0 is less than -1.0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 64 | Operand A (single precision in bits [31:0]) |
| op_b | input | 64 | Operand B (single precision in bits [31:0]) |
| dbl_sel | input | 1 | 1 selects double precision, 0 selects single precision |
| sig_mode | input | 1 | 1 selects signalling compare, 0 selects quiet compare |
| nzcv | output | 4 | Condition nibble: N bit 3, Z bit 2, C bit 1, V bit 0 |
| invalid | output | 1 | Invalid-operation exception flag |

## Verification
The assertions assume that op_a, op_b, dbl_sel and sig_mode are known (non-X) in every cycle after reset. They also assume that these inputs change only away from the rising edge, because the checks relate each registered result to the inputs sampled one edge earlier. The bench meets both conditions: it drives every input from time zero and changes them only on falling edges. Its vectors cover each ordering, both NaN kinds in both modes, both zero signs, both infinities, and single-precision operands whose upper 32 bits hold garbage, including patterns that would be NaNs if read as doubles.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } fpcmp_rel_e;

  localparam logic [3:0] NZCV_EQ = 4'b0110;
  localparam logic [3:0] NZCV_LT = 4'b1000;
  localparam logic [3:0] NZCV_GT = 4'b0010;
  localparam logic [3:0] NZCV_UN = 4'b0011;

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned MAG_W  = 63,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]     bits,
  output logic             sign,
  output logic             is_nan,
  output logic             is_snan,
  output logic             is_zero,
  output logic [MAG_W-1:0] mag
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    sign    = bits[W-1];
    expo    = bits[W-2:FRAC_W];
    frac    = bits[FRAC_W-1:0];
    is_nan  = (&expo) & (|frac);
    is_snan = is_nan & ~frac[FRAC_W-1];
    is_zero = ~|bits[W-2:0];
    mag     = MAG_W'(bits[W-2:0]);
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int unsigned MAG_W = 63
) (
  input  logic             a_sign,
  input  logic             a_nan,
  input  logic             a_zero,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic             b_nan,
  input  logic             b_zero,
  input  logic [MAG_W-1:0] b_mag,
  output fpcmp_rel_e       rel
);
  logic mag_lt;
  logic mag_eq;

  always_comb begin
    mag_lt = a_mag < b_mag;
    mag_eq = a_mag == b_mag;
    if (a_nan || b_nan)
      rel = REL_UN;
    else if (a_zero && b_zero)
      rel = REL_EQ;
    else if (a_sign != b_sign)
      rel = a_sign ? REL_LT : REL_GT;
    else if (mag_eq)
      rel = REL_EQ;
    else if (mag_lt ^ a_sign)
      rel = REL_LT;
    else
      rel = REL_GT;
  end
endmodule

// File: rtl/fpcmp_encode.sv
module fpcmp_encode
  import fpcmp_pkg::*;
(
  input  fpcmp_rel_e rel,
  input  logic       sig_mode,
  input  logic       any_nan,
  input  logic       any_snan,
  output logic [3:0] nzcv,
  output logic       invalid
);
  always_comb begin
    unique case (rel)
      REL_EQ:  nzcv = NZCV_EQ;
      REL_LT:  nzcv = NZCV_LT;
      REL_GT:  nzcv = NZCV_GT;
      default: nzcv = NZCV_UN;
    endcase
    invalid = sig_mode ? any_nan : any_snan;
  end
endmodule

// File: rtl/fpcmp_top.sv
module fpcmp_top
  import fpcmp_pkg::*;
#(
  parameter int unsigned S_EXP_W  = 8,
  parameter int unsigned S_FRAC_W = 23,
  parameter int unsigned D_EXP_W  = 11,
  parameter int unsigned D_FRAC_W = 52,
  parameter bit          OUT_REG  = 1'b1,
  localparam int unsigned SGL_W   = 1 + S_EXP_W + S_FRAC_W,
  localparam int unsigned DBL_W   = 1 + D_EXP_W + D_FRAC_W,
  localparam int unsigned MAG_W   = DBL_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DBL_W-1:0] op_a,
  input  logic [DBL_W-1:0] op_b,
  input  logic             dbl_sel,
  input  logic             sig_mode,
  output logic [3:0]       nzcv,
  output logic             invalid
);
  localparam int unsigned NOPS = 2;

  logic [NOPS-1:0][DBL_W-1:0] ops;
  logic [NOPS-1:0]             s_sign, s_nan, s_snan, s_zero;
  logic [NOPS-1:0]             d_sign, d_nan, d_snan, d_zero;
  logic [NOPS-1:0][MAG_W-1:0]  s_mag, d_mag;
  logic [NOPS-1:0]             u_sign, u_nan, u_snan, u_zero;
  logic [NOPS-1:0][MAG_W-1:0]  u_mag;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    fpcmp_unpack #(.EXP_W(S_EXP_W), .FRAC_W(S_FRAC_W), .MAG_W(MAG_W)) u_sgl (
      .bits   (ops[g][SGL_W-1:0]),
      .sign   (s_sign[g]),
      .is_nan (s_nan[g]),
      .is_snan(s_snan[g]),
      .is_zero(s_zero[g]),
      .mag    (s_mag[g])
    );
    fpcmp_unpack #(.EXP_W(D_EXP_W), .FRAC_W(D_FRAC_W), .MAG_W(MAG_W)) u_dbl (
      .bits   (ops[g]),
      .sign   (d_sign[g]),
      .is_nan (d_nan[g]),
      .is_snan(d_snan[g]),
      .is_zero(d_zero[g]),
      .mag    (d_mag[g])
    );
    always_comb begin
      u_sign[g] = dbl_sel ? d_sign[g] : s_sign[g];
      u_nan[g]  = dbl_sel ? d_nan[g]  : s_nan[g];
      u_snan[g] = dbl_sel ? d_snan[g] : s_snan[g];
      u_zero[g] = dbl_sel ? d_zero[g] : s_zero[g];
      u_mag[g]  = dbl_sel ? d_mag[g]  : s_mag[g];
    end
  end

  fpcmp_rel_e rel;
  logic [3:0] nzcv_c;
  logic       inv_c;

  fpcmp_order #(.MAG_W(MAG_W)) u_order (
    .a_sign(u_sign[0]), .a_nan(u_nan[0]), .a_zero(u_zero[0]), .a_mag(u_mag[0]),
    .b_sign(u_sign[1]), .b_nan(u_nan[1]), .b_zero(u_zero[1]), .b_mag(u_mag[1]),
    .rel   (rel)
  );

  fpcmp_encode u_encode (
    .rel     (rel),
    .sig_mode(sig_mode),
    .any_nan (|u_nan),
    .any_snan(|u_snan),
    .nzcv    (nzcv_c),
    .invalid (inv_c)
  );

  if (OUT_REG) begin : g_oreg
    logic [3:0] nzcv_q;
    logic       inv_q;
    logic       vld_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        nzcv_q <= '0;
        inv_q  <= 1'b0;
        vld_q  <= 1'b0;
      end else begin
        nzcv_q <= nzcv_c;
        inv_q  <= inv_c;
        vld_q  <= 1'b1;
      end
    end
    assign nzcv    = nzcv_q;
    assign invalid = inv_q;

    logic in_both_zero;
    assign in_both_zero = dbl_sel ?
      ((op_a[DBL_W-2:0] == '0) && (op_b[DBL_W-2:0] == '0)) :
      ((op_a[SGL_W-2:0] == '0) && (op_b[SGL_W-2:0] == '0));

    // R1 R2 R3 R4: only the four defined nibbles ever leave the block
    a_r4_legal_flags: assert property (@(posedge clk) disable iff (rst)
      vld_q |-> (nzcv == NZCV_EQ || nzcv == NZCV_LT || nzcv == NZCV_GT || nzcv == NZCV_UN));

    // R7: invalid is only raised alongside an unordered result
    a_r7_inv_only_unordered: assert property (@(posedge clk) disable iff (rst)
      (vld_q && invalid) |-> (nzcv == NZCV_UN));

    // R8: signalling compare raises invalid on every unordered result
    a_r8_sig_unordered_inv: assert property (@(posedge clk) disable iff (rst)
      (vld_q && $past(sig_mode) && nzcv == NZCV_UN) |-> invalid);

    // R5: any pair of zeros compares equal without invalid
    a_r5_zero_equal: assert property (@(posedge clk) disable iff (rst)
      (vld_q && $past(in_both_zero)) |-> (nzcv == NZCV_EQ && !invalid));

    // R10: first result after reset is the cleared value
    a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
      !vld_q |-> (nzcv == 4'b0000 && !invalid));
  end else begin : g_comb
    assign nzcv    = nzcv_c;
    assign invalid = inv_c;
  end
endmodule

// File: tb/tb_fpcmp_top.sv
module tb_fpcmp_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        dbl_sel = 1'b0;
  logic        sig_mode = 1'b0;
  logic [3:0]  nzcv;
  logic        invalid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] e_nzcv;
    logic       e_inv;
    string      tag;
  } exp_t;

  exp_t sb[$];

  localparam logic [3:0] F_EQ = 4'b0110, F_LT = 4'b1000, F_GT = 4'b0010, F_UN = 4'b0011;

  always #2 clk = ~clk;

  fpcmp_top dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .dbl_sel(dbl_sel), .sig_mode(sig_mode), .nzcv(nzcv), .invalid(invalid)
  );

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                       input logic sig, input logic [3:0] en, input logic ei, input string tag);
    exp_t e;
    @(negedge clk);
    op_a = a; op_b = b; dbl_sel = dbl; sig_mode = sig;
    e.e_nzcv = en; e.e_inv = ei; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: one result per edge, one cycle behind the driver (R10)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        compared++;
        if (nzcv !== e.e_nzcv || invalid !== e.e_inv) begin
          mismatched++;
          $display("FAIL %s: nzcv=%b invalid=%b expected nzcv=%b invalid=%b",
                   e.tag, nzcv, invalid, e.e_nzcv, e.e_inv);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  localparam logic [31:0] S1 = 32'h3F80_0000, S2 = 32'h4000_0000, SN1 = 32'hBF80_0000,
    SN2 = 32'hC000_0000, SPZ = 32'h0, SNZ = 32'h8000_0000, SPI = 32'h7F80_0000,
    SNI = 32'hFF80_0000, SQN = 32'h7FC0_0000, SSN = 32'h7F80_0001;
  localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D1U = 64'h3FF0_0000_0000_0001,
    D2 = 64'h4000_0000_0000_0000, DN1 = 64'hBFF0_0000_0000_0000, DNZ = 64'h8000_0000_0000_0000,
    DPI = 64'h7FF0_0000_0000_0000, DNI = 64'hFFF0_0000_0000_0000,
    DQN = 64'h7FF8_0000_0000_0000, DSN = 64'h7FF0_0000_0000_0001;

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (nzcv !== 4'b0000 || invalid !== 1'b0) begin
      mismatched++;
      $display("FAIL R10 reset: nzcv=%b invalid=%b expected nzcv=0000 invalid=0", nzcv, invalid);
    end
    @(negedge clk);
    rst = 1'b0;

    // single precision
    drive({32'h0, S1},  {32'h0, S2},  0, 0, F_LT, 0, "R2 s 1<2");
    drive({32'h0, S2},  {32'h0, S1},  0, 0, F_GT, 0, "R3 s 2>1");
    drive({32'h0, S1},  {32'h0, S1},  0, 0, F_EQ, 0, "R1 s 1==1");
    drive({32'h0, SPZ}, {32'h0, SNZ}, 0, 1, F_EQ, 0, "R5 s +0==-0");
    drive({32'h0, SNZ}, {32'h0, SPZ}, 0, 0, F_EQ, 0, "R5 s -0==+0");
    drive({32'h0, SN1}, {32'h0, SN2}, 0, 0, F_GT, 0, "R11 s -1>-2");
    drive({32'h0, SN2}, {32'h0, SN1}, 0, 0, F_LT, 0, "R11 s -2<-1");
    drive({32'h0, SNI}, {32'h0, SN2}, 0, 0, F_LT, 0, "R6 s -inf<-2");
    drive({32'h0, SPI}, {32'h0, S2},  0, 0, F_GT, 0, "R6 s +inf>2");
    drive({32'h0, SPI}, {32'h0, SPI}, 0, 0, F_EQ, 0, "R6 s inf==inf");
    drive({32'h0, SQN}, {32'h0, S1},  0, 0, F_UN, 0, "R4 R7 s qnan quiet");
    drive({32'h0, SQN}, {32'h0, S1},  0, 1, F_UN, 1, "R8 s qnan signalling");
    drive({32'h0, S1},  {32'h0, SSN}, 0, 0, F_UN, 1, "R7 s snan quiet");
    drive({32'h0, S1},  {32'h0, SSN}, 0, 1, F_UN, 1, "R8 s snan signalling");
    drive({32'hFFFF_FFFF, S1}, {32'h1234_5678, S2}, 0, 0, F_LT, 0, "R9 s upper ignored");
    drive({32'h7FF8_0000, S2}, {32'h0, S2}, 0, 1, F_EQ, 0, "R9 s upper nan ignored");

    // double precision
    drive(D1,  D2,  1, 0, F_LT, 0, "R2 d 1<2");
    drive(D2,  D1,  1, 0, F_GT, 0, "R3 d 2>1");
    drive(D1,  D1U, 1, 0, F_LT, 0, "R9 d low bit used");
    drive(D1U, D1,  1, 0, F_GT, 0, "R9 d low bit used rev");
    drive(DNZ, 64'h0, 1, 0, F_EQ, 0, "R5 d -0==+0");
    drive(DN1, D1,  1, 0, F_LT, 0, "R2 d -1<1");
    drive(DNI, DNI, 1, 0, F_EQ, 0, "R6 d -inf==-inf");
    drive(DPI, DNI, 1, 0, F_GT, 0, "R6 d +inf>-inf");
    drive(DQN, D1,  1, 0, F_UN, 0, "R4 R7 d qnan quiet");
    drive(D1,  DQN, 1, 1, F_UN, 1, "R8 d qnan signalling");
    drive(DSN, D2,  1, 0, F_UN, 1, "R7 d snan quiet");
    drive(DQN, DSN, 1, 0, F_UN, 1, "R7 d qnan+snan quiet");

    // double sweep checked against real-number ordering (R1 R2 R3 R11)
    for (int i = 0; i < 40; i++) begin
      real ra, rb;
      logic [3:0] ex;
      ra = (i % 11) * 1.25 - 6.0;
      rb = (i % 7) * 1.75 - 5.0;
      ex = (ra == rb) ? F_EQ : ((ra < rb) ? F_LT : F_GT);
      drive($realtobits(ra), $realtobits(rb), 1, i[0], ex, 0, "R1 R2 R3 d sweep");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule